// File: doc/BRIEF.md
# Latched Event Interrupt Controller

This block gathers seven event sources into sticky status flags and combines them into one interrupt line. The sources are four capture events, a counter-overflow event, a period-match event and a compare-match event. Each source pulse sets its own flag, and the flag stays set until software clears it. Software can also set any flag on purpose for test. A per-source enable decides whether a pending flag may raise the interrupt.

The interrupt comes from a global flag that latches once and then stays set. It blocks any further assertion until software clears it through the clear register. If enabled flags are still pending when the global flag is cleared, the line drops for one clock and then rises again. An edge-sensitive consumer therefore sees a fresh interrupt.

A mode input qualifies the sources. Capture events count only in capture mode, and the period and compare matches count only in PWM mode. Overflow counts in both modes. Software reaches four register slots through a plain write strobe and a combinational read strobe.

Top module: `irq_event_latch`

## Requirements
- R1: After synchronous reset, all event flags, all enable bits, the global flag and `irq` are 0.
- R2: A source pulse that is live in the current mode sets its flag at the next clock edge. The flag then stays set until it is cleared. Flag positions: bit 1..4 = capture 1..4, bit 5 = overflow, bit 6 = period match, bit 7 = compare match.
- R3: When `pwm_mode`=1, capture pulses are ignored. When `pwm_mode`=0, period-match and compare-match pulses are ignored. Overflow pulses are honoured in both modes.
- R4: An event flag is set whatever its enable bit says. A flag whose enable bit is 0 never raises the global flag.
- R5: Writing slot 2 (clear) with a 1 in a bit clears that flag, where bit 0 is the global flag. A 0 bit leaves its flag unchanged. Reading slot 2 returns 0.
- R6: Writing slot 3 (force) with a 1 in bit 1..7 sets that event flag in either mode. Bit 0 and bits 15:8 have no effect. Reading slot 3 returns 0.
- R7: When a flag receives a set (pulse or force) in the same clock as a clear, the flag ends up set.
- R8: When the global flag is 0 and some flag is set with its enable bit at 1, the global flag becomes 1 at the next edge, unless it is being cleared in that clock. `irq` equals the global flag.
- R9: Once set, the global flag holds through further events until a clear-register write with bit 0 = 1.
- R10: Clearing the global flag while enabled flags remain set makes `irq` 0 for exactly one clock and then 1 again.
- R11: Slot 0 holds the enables in bits 7:1 and is written whole. Reading slot 0 shows them, with bit 0 and bits 15:8 as 0. Reading slot 1 shows the global flag in bit 0 and the event flags in bits 7:1, with bits 15:8 as 0. With `rd_en`=0, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write slot: 0 enable, 1 flags (read only), 2 clear, 3 force |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read slot, same coding as wr_addr |
| rd_data | output | 16 | Combinational read data |
| pwm_mode | input | 1 | 0 capture mode, 1 PWM mode |
| cap_evt | input | 4 | Capture event pulses, bit i = capture i+1 |
| ovf_evt | input | 1 | Counter overflow pulse |
| prd_evt | input | 1 | Period match pulse |
| cmp_evt | input | 1 | Compare match pulse |
| irq | output | 1 | Interrupt line, equal to the global flag |

## Verification
Directed sequences come first. They separate several pairs of behaviours: a first interrupt from one held while latched; a clear of the global flag alone, which must re-raise, from a full clear, which must not; events that arrive with enables off, which set flags but no interrupt; and the two modes, each of which must mask a different group of sources. Further cases put a pulse and a clear of the same flag in one clock, and force every flag at once. A long random phase follows. It mixes sparse pulses, mode flips and random writes to every slot. This exposes interactions between clears, forces and re-raises that the directed cases do not line up.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_FLAGS  = 2'd1,
        SEL_CLEAR  = 2'd2,
        SEL_FORCE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic en_wr;
        logic clr_wr;
        logic frc_wr;
    } wr_strobe_t;

    localparam int GLOBAL_BIT = 0;

    // Which flag bits accept source pulses in the given mode.
    // Layout: 1..ncap capture, ncap+1 overflow, ncap+2 period, ncap+3 compare.
    function automatic logic [31:0] live_mask(input logic pwm, input int ncap);
        logic [31:0] m;
        m = '0;
        for (int i = 1; i <= ncap; i++) begin
            m[i] = ~pwm;
        end
        m[ncap + 1] = 1'b1;
        m[ncap + 2] = pwm;
        m[ncap + 3] = pwm;
        return m;
    endfunction

endpackage

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_latch_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_addr,
    input  logic [FLAG_W-1:0] status_q,
    output logic [FLAG_W-1:0] clr_bits,
    output logic [FLAG_W-1:1] frc_bits,
    output logic [FLAG_W-1:1] enable_q,
    output logic [REG_W-1:0]  rd_data
);

    wr_strobe_t stb;
    logic       unused_hi;

    assign unused_hi = ^wr_data[REG_W-1:FLAG_W];

    always_comb begin
        stb = '0;
        if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_ENABLE: stb.en_wr  = 1'b1;
                SEL_CLEAR:  stb.clr_wr = 1'b1;
                SEL_FORCE:  stb.frc_wr = 1'b1;
                default:    ;
            endcase
        end
    end

    assign clr_bits = stb.clr_wr ? wr_data[FLAG_W-1:0] : '0;
    assign frc_bits = stb.frc_wr ? wr_data[FLAG_W-1:1] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
        end else if (stb.en_wr) begin
            enable_q <= wr_data[FLAG_W-1:1];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (reg_sel_e'(rd_addr))
                SEL_ENABLE: rd_data[FLAG_W-1:1] = enable_q;
                SEL_FLAGS:  rd_data[FLAG_W-1:0] = status_q;
                default:    rd_data = '0;
            endcase
        end
    end

    // R11: the enable register changes only on its own write
    p_enable_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == SEL_ENABLE) |=> $stable(enable_q));

    // R11: an enable write loads the written bits
    p_enable_load_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == SEL_ENABLE) |=> enable_q == $past(wr_data[FLAG_W-1:1]));

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NUM = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] set_evt,
    input  logic [NUM-1:0] set_frc,
    input  logic [NUM-1:0] clr,
    output logic [NUM-1:0] flags_q
);

    for (genvar g = 0; g < NUM; g++) begin : g_cell
        logic set_any;
        assign set_any = set_evt[g] | set_frc[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[g] <= 1'b0;
            end else if (set_any) begin
                flags_q[g] <= 1'b1;
            end else if (clr[g]) begin
                flags_q[g] <= 1'b0;
            end
        end

        // R7: a set in the same clock as a clear leaves the flag set
        p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
            (set_evt[g] || set_frc[g]) |=> flags_q[g]);

        // R5: a clear alone drops the flag
        p_clear_r5: assert property (@(posedge clk) disable iff (rst)
            (clr[g] && !set_evt[g] && !set_frc[g]) |=> !flags_q[g]);

        // R2: a set flag stays set without a clear
        p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
            (flags_q[g] && !clr[g]) |=> flags_q[g]);
    end

endmodule

// File: rtl/irq_global_latch.sv
module irq_global_latch (
    input  logic clk,
    input  logic rst,
    input  logic pending,
    input  logic clr_glb,
    output logic glb_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_q <= 1'b0;
        end else if (clr_glb) begin
            glb_q <= 1'b0;
        end else if (pending) begin
            glb_q <= 1'b1;
        end
    end

    // R9: latched until explicitly cleared
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (glb_q && !clr_glb) |=> glb_q);

    // R8: an enabled pending flag raises the global flag
    p_raise_r8: assert property (@(posedge clk) disable iff (rst)
        (!glb_q && pending && !clr_glb) |=> glb_q);

    // R8: nothing pending keeps it low
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!glb_q && !pending) |=> !glb_q);

    // R10: a clear always produces a low clock
    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clr_glb |=> !glb_q);

endmodule

// File: rtl/irq_event_latch.sv
module irq_event_latch
    import irq_latch_pkg::*;
#(
    parameter int NUM_CAP = 4,
    parameter int REG_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               rd_en,
    input  logic [1:0]         rd_addr,
    output logic [REG_W-1:0]   rd_data,
    input  logic               pwm_mode,
    input  logic [NUM_CAP-1:0] cap_evt,
    input  logic               ovf_evt,
    input  logic               prd_evt,
    input  logic               cmp_evt,
    output logic               irq
);

    localparam int FLAG_W = NUM_CAP + 4;
    localparam int EVT_N  = FLAG_W - 1;

    logic [31:0]       live_all;
    logic              unused_live;
    logic [EVT_N-1:0]  src_evt;
    logic [EVT_N-1:0]  evt_q;
    logic [FLAG_W-1:0] clr_bits;
    logic [FLAG_W-1:1] frc_bits;
    logic [FLAG_W-1:1] enable_q;
    logic [FLAG_W-1:0] status_q;
    logic              pending;
    logic              glb_q;

    assign live_all    = live_mask(pwm_mode, NUM_CAP);
    assign unused_live = ^{live_all[31:FLAG_W], live_all[0]};
    assign src_evt     = {cmp_evt, prd_evt, ovf_evt, cap_evt} & live_all[FLAG_W-1:1];

    irq_reg_port #(
        .REG_W  (REG_W),
        .FLAG_W (FLAG_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .status_q (status_q),
        .clr_bits (clr_bits),
        .frc_bits (frc_bits),
        .enable_q (enable_q),
        .rd_data  (rd_data)
    );

    irq_flag_bank #(
        .NUM (EVT_N)
    ) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_evt (src_evt),
        .set_frc (frc_bits),
        .clr     (clr_bits[FLAG_W-1:1]),
        .flags_q (evt_q)
    );

    assign pending = |(evt_q & enable_q);

    irq_global_latch u_glb (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .clr_glb (clr_bits[GLOBAL_BIT]),
        .glb_q   (glb_q)
    );

    assign status_q = {evt_q, glb_q};
    assign irq      = glb_q;

    // R8: every rising edge of the line is caused by an enabled pending flag
    p_rise_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(pending));

    // R3: a capture pulse in PWM mode does not set a clear capture flag
    p_cap_masked_r3: assert property (@(posedge clk) disable iff (rst)
        (pwm_mode && cap_evt[0] && !evt_q[0] && !frc_bits[1]) |=> !evt_q[0]);

endmodule

// File: tb/irq_event_latch_test.sv
`timescale 1ns/1ps
module irq_event_latch_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic        rd_en;
    logic [1:0]  rd_addr;
    logic [15:0] rd_data;
    logic        pwm_mode;
    logic [3:0]  cap_evt;
    logic        ovf_evt;
    logic        prd_evt;
    logic        cmp_evt;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:1] m_ev;
    logic [7:1] m_en;
    logic       m_g;

    always #10 clk = ~clk;

    irq_event_latch uut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .pwm_mode (pwm_mode),
        .cap_evt  (cap_evt),
        .ovf_evt  (ovf_evt),
        .prd_evt  (prd_evt),
        .cmp_evt  (cmp_evt),
        .irq      (irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_flags();
        return {8'h00, m_ev, m_g};
    endfunction

    // Drive one clock of stimulus, advance the model, check at the next negedge.
    task automatic apply(input logic we, input logic [1:0] wa, input logic [15:0] wd,
                         input logic pwm, input logic [3:0] cap,
                         input logic o, input logic p, input logic c, input string tag);
        logic [7:1] src;
        logic [7:1] frc;
        logic [7:0] clr;
        logic [7:1] nev;
        logic [7:1] nen;
        logic       pend;
        logic       ng;
        wr_en = we; wr_addr = wa; wr_data = wd;
        pwm_mode = pwm; cap_evt = cap; ovf_evt = o; prd_evt = p; cmp_evt = c;
        src  = pwm ? {c, p, o, 4'b0000} : {1'b0, 1'b0, o, cap};
        frc  = (we && wa == 2'd3) ? wd[7:1] : 7'h00;
        clr  = (we && wa == 2'd2) ? wd[7:0] : 8'h00;
        for (int i = 1; i <= 7; i++) begin
            nev[i] = (src[i] | frc[i]) ? 1'b1 : (clr[i] ? 1'b0 : m_ev[i]);
        end
        pend = |(m_ev & m_en);
        ng   = clr[0] ? 1'b0 : (m_g | pend);
        nen  = (we && wa == 2'd0) ? wd[7:1] : m_en;
        @(posedge clk);
        m_ev = nev; m_g = ng; m_en = nen;
        @(negedge clk);
        wr_en = 1'b0; cap_evt = '0; ovf_evt = 1'b0; prd_evt = 1'b0; cmp_evt = 1'b0;
        rd_en = 1'b1; rd_addr = 2'd1; #1;
        chk(rd_data == exp_flags(), {tag, " flags"}, rd_data, exp_flags());
        chk(irq == m_g, {tag, " irq"}, {15'h0, irq}, {15'h0, m_g});
        rd_addr = 2'd0; #1;
        chk(rd_data == {8'h00, m_en, 1'b0}, {tag, " enable"}, rd_data, {8'h00, m_en, 1'b0});
    endtask

    task automatic idle(input logic pwm, input string tag);
        apply(1'b0, 2'd0, 16'h0000, pwm, 4'h0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic pwm_r;
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_en = 1'b0; rd_addr = '0;
        pwm_mode = 1'b0; cap_evt = '0; ovf_evt = 1'b0; prd_evt = 1'b0; cmp_evt = 1'b0;
        m_ev = '0; m_en = '0; m_g = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd_en = 1'b1; rd_addr = 2'd1; #1;
        chk(rd_data == 16'h0000, "R1 flags after reset", rd_data, 16'h0000);
        chk(irq == 1'b0, "R1 irq after reset", {15'h0, irq}, 16'h0000);
        rd_addr = 2'd0; #1;
        chk(rd_data == 16'h0000, "R1 enable after reset", rd_data, 16'h0000);
        rd_en = 1'b0; #1;
        chk(rd_data == 16'h0000, "R11 no read strobe", rd_data, 16'h0000);

        apply(1'b1, 2'd0, 16'hFFFE, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, "R11 enable write");
        apply(1'b0, 2'd0, 16'h0000, 1'b0, 4'b0001, 1'b0, 1'b0, 1'b0, "R2 capture 1");
        chk(irq == 1'b0, "R8 not yet raised", {15'h0, irq}, 16'h0000);
        idle(1'b0, "R8 one clock later");
        chk(irq == 1'b1, "R8 raised", {15'h0, irq}, 16'h0001);
        apply(1'b0, 2'd0, 16'h0000, 1'b0, 4'b0010, 1'b0, 1'b0, 1'b0, "R9 event while latched");
        apply(1'b1, 2'd2, 16'h0001, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, "R10 clear global only");
        chk(irq == 1'b0, "R10 low for one clock", {15'h0, irq}, 16'h0000);
        idle(1'b0, "R10 re-raise");
        chk(irq == 1'b1, "R10 raised again", {15'h0, irq}, 16'h0001);
        apply(1'b1, 2'd2, 16'h00FF, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, "R5 clear all");
        idle(1'b0, "R5 stays clear");
        chk(irq == 1'b0, "R5 no re-raise", {15'h0, irq}, 16'h0000);

        apply(1'b1, 2'd0, 16'h0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, "R4 enables off");
        apply(1'b0, 2'd0, 16'h0000, 1'b0, 4'hF, 1'b1, 1'b0, 1'b0, "R4 events with enables off");
        idle(1'b0, "R4 wait");
        idle(1'b0, "R4 wait");
        chk(irq == 1'b0, "R4 no interrupt", {15'h0, irq}, 16'h0000);

        apply(1'b1, 2'd2, 16'h00FF, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, "R5 clear all");
        apply(1'b0, 2'd0, 16'h0000, 1'b1, 4'hF, 1'b0, 1'b1, 1'b1, "R3 pwm mode");
        rd_addr = 2'd1; #1;
        chk(rd_data == 16'h00C0, "R3 pwm masks captures", rd_data, 16'h00C0);
        apply(1'b1, 2'd2, 16'h00FF, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, "R5 clear all");
        apply(1'b0, 2'd0, 16'h0000, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1, "R3 capture mode");
        rd_addr = 2'd1; #1;
        chk(rd_data == 16'h0020, "R3 capture masks matches", rd_data, 16'h0020);
        apply(1'b1, 2'd2, 16'h0020, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, "R7 overflow with clear");
        rd_addr = 2'd1; #1;
        chk(rd_data == 16'h0020, "R7 set wins", rd_data, 16'h0020);
        apply(1'b1, 2'd3, 16'hFFFF, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, "R6 force all");
        rd_addr = 2'd1; #1;
        chk(rd_data == 16'h00FE, "R6 forced flags", rd_data, 16'h00FE);
        rd_addr = 2'd2; #1;
        chk(rd_data == 16'h0000, "R5 clear slot reads zero", rd_data, 16'h0000);
        rd_addr = 2'd3; #1;
        chk(rd_data == 16'h0000, "R6 force slot reads zero", rd_data, 16'h0000);

        pwm_r = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            logic       we;
            logic [1:0] wa;
            logic [3:0] cap;
            if ($urandom % 32 == 0) pwm_r = ~pwm_r;
            we = ($urandom % 4 == 0);
            wa = 2'($urandom);
            for (int b = 0; b < 4; b++) cap[b] = ($urandom % 8 == 0);
            apply(we, wa, 16'($urandom), pwm_r, cap,
                  ($urandom % 8 == 0), ($urandom % 8 == 0), ($urandom % 8 == 0),
                  "R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule